// File: doc/BRIEF.md
# Sensor Sample FIFO with Watermark and Overrun Flags

This block stores three-axis sensor samples between the sampling logic and a host. Each data-ready strobe offers one X/Y/Z sample. Each host read of a complete sample removes one. The oldest unread sample is always shown on the head outputs. The block drives an entry count, a data-available line and two status flags for the interrupt logic.

The block has two modes. In bypass mode it keeps a single holding slot: a new sample always replaces the old one. In buffered mode it keeps up to DEPTH samples in arrival order.

The watermark flag reports that the fill level has reached a programmed sample count. The overrun flag reports data loss in bypass mode and a full store in buffered mode. Any change of mode empties the store and clears both flags.

Top module: `sample_fifo`

## Requirements
- R1: After reset, count_o is 0, and avail_o, wm_o and ovr_o are all 0.
- R2: In buffered mode (mode_i = 1), samples leave in the order they were written. The head outputs always show the oldest stored sample. A read (rd_i) removes that sample, and count_o falls by one at the same clock edge.
- R3: In buffered mode, count_o never exceeds DEPTH (default 32). A write that arrives while the store is full and no read is present is dropped, and the stored samples are unchanged.
- R4: In buffered mode, a read and a write in the same cycle are both performed, and count_o is unchanged. This holds even when the store is full.
- R5: In buffered mode with wm_level_i = L and L nonzero, wm_o is 1 exactly when count_o >= L. It rises at the edge where the count reaches L and falls at the edge where reads bring the count below L. With L = 0, wm_o stays 0.
- R6: In buffered mode, ovr_o goes to 1 at the edge where count_o reaches DEPTH. It returns to 0 at the first read that leaves the store below full.
- R7: In bypass mode (mode_i = 0), count_o is only ever 0 or 1. Every write is stored, and the head outputs show the most recently written sample.
- R8: In bypass mode, a write while a sample is held and no read is present sets ovr_o. A read clears ovr_o. A write together with a read in the same cycle does not set ovr_o.
- R9: When mode_i differs from the mode in use, the next edge empties the store and clears wm_o and ovr_o. A read or write in that cycle has no effect.
- R10: avail_o is 1 exactly when count_o is nonzero.
- R11: A read while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Mode select: 0 bypass, 1 buffered |
| wm_level_i | input | $clog2(DEPTH) | Watermark sample count; 0 disables the watermark |
| wr_i | input | 1 | Data-ready strobe; offers one sample |
| x_i | input | 16 | X axis of the offered sample |
| y_i | input | 16 | Y axis of the offered sample |
| z_i | input | 16 | Z axis of the offered sample |
| rd_i | input | 1 | Host finished reading the head sample (last Z byte read) |
| head_x_o | output | 16 | X axis of the oldest stored sample |
| head_y_o | output | 16 | Y axis of the oldest stored sample |
| head_z_o | output | 16 | Z axis of the oldest stored sample |
| count_o | output | $clog2(DEPTH+1) | Number of stored samples |
| avail_o | output | 1 | At least one unread sample is stored |
| wm_o | output | 1 | Watermark flag |
| ovr_o | output | 1 | Overrun flag |

## Verification
The count, the data-available line and both flags are registered. They take their new values at the first rising edge that sees a strobe, and each of them reflects that edge's push, pop or flush. The head outputs are read combinationally from the state that edge leaves behind.

The bench drives each stimulus just after a falling edge and holds it for exactly one rising edge. It samples every result one time unit after that edge, before the next stimulus can act. The head is therefore compared with the expected sample before the read that removes it. A mode change is checked one edge after it is applied.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int AXIS_W = 16;

    typedef struct packed {
        logic [AXIS_W-1:0] x;
        logic [AXIS_W-1:0] y;
        logic [AXIS_W-1:0] z;
    } sample_t;

    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_FIFO   = 1'b1
    } fmode_e;

    // Next entry count for the buffered mode.
    function automatic int unsigned fifo_next_count(int unsigned cnt, logic push, logic pop);
        return cnt + (push ? 1 : 0) - (pop ? 1 : 0);
    endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fmode_e        mode_i,
    input  logic          wr_i,
    input  logic          rd_i,
    output fmode_e        mode_q,
    output logic          flush,
    output logic          push,
    output logic          pop,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_n
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    always_comb begin
        flush = (mode_i != mode_q);
        pop   = !flush && rd_i && (cnt_q != '0);
        if (mode_q == MODE_BYPASS) begin
            push = !flush && wr_i;
        end else begin
            push = !flush && wr_i && ((cnt_q != FULL) || pop);
        end

        if (flush) begin
            cnt_n = '0;
        end else if (mode_q == MODE_BYPASS) begin
            if (push)      cnt_n = CW'(1);
            else if (pop)  cnt_n = '0;
            else           cnt_n = cnt_q;
        end else begin
            cnt_n = CW'(fifo_next_count(int'(cnt_q), push, pop));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_BYPASS;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_i;
            cnt_q  <= cnt_n;
        end
    end

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    bypass,
    input  logic    push,
    input  logic    pop,
    input  sample_t wdata,
    output sample_t rdata
);

    sample_t        mem [DEPTH];
    logic [AW-1:0]  wptr;
    logic [AW-1:0]  rptr;
    logic [AW-1:0]  waddr;

    // Bypass mode keeps its single holding slot at entry 0.
    assign waddr = bypass ? '0 : wptr;
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || flush || bypass) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[waddr] <= wdata;
    end

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  fmode_e        mode_q,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] cnt_n,
    input  logic [LW-1:0] level,
    output logic          wm_q,
    output logic          ovr_q
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic wm_d;
    logic ovr_d;

    always_comb begin
        wm_d  = 1'b0;
        ovr_d = ovr_q;
        if (flush) begin
            ovr_d = 1'b0;
        end else if (mode_q == MODE_BYPASS) begin
            if (push && (cnt_q != '0) && !pop) ovr_d = 1'b1;
            else if (pop)                      ovr_d = 1'b0;
        end else begin
            wm_d = (level != '0) && (cnt_n >= CW'(level));
            if (cnt_n == FULL) ovr_d = 1'b1;
            else if (pop)      ovr_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            wm_q  <= wm_d;
            ovr_q <= ovr_d;
        end
    end

endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic [LW-1:0]     wm_level_i,
    input  logic              wr_i,
    input  logic [AXIS_W-1:0] x_i,
    input  logic [AXIS_W-1:0] y_i,
    input  logic [AXIS_W-1:0] z_i,
    input  logic              rd_i,
    output logic [AXIS_W-1:0] head_x_o,
    output logic [AXIS_W-1:0] head_y_o,
    output logic [AXIS_W-1:0] head_z_o,
    output logic [CW-1:0]     count_o,
    output logic              avail_o,
    output logic              wm_o,
    output logic              ovr_o
);

    fmode_e        mode_q;
    logic          flush;
    logic          push;
    logic          pop;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_n;
    sample_t       wdata;
    sample_t       head;

    assign wdata = '{x: x_i, y: y_i, z: z_i};

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .mode_i (fmode_e'(mode_i)),
        .wr_i   (wr_i),
        .rd_i   (rd_i),
        .mode_q (mode_q),
        .flush  (flush),
        .push   (push),
        .pop    (pop),
        .cnt_q  (cnt_q),
        .cnt_n  (cnt_n)
    );

    sfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .bypass (mode_q == MODE_BYPASS),
        .push   (push),
        .pop    (pop),
        .wdata  (wdata),
        .rdata  (head)
    );

    sfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .mode_q (mode_q),
        .flush  (flush),
        .push   (push),
        .pop    (pop),
        .cnt_q  (cnt_q),
        .cnt_n  (cnt_n),
        .level  (wm_level_i),
        .wm_q   (wm_o),
        .ovr_q  (ovr_o)
    );

    assign head_x_o = head.x;
    assign head_y_o = head.y;
    assign head_z_o = head.z;
    assign count_o  = cnt_q;
    assign avail_o  = (cnt_q != '0);

endmodule

// File: rtl/sample_fifo_chk.sv
module sample_fifo_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_i,
    input logic [LW-1:0] wm_level_i,
    input logic          wr_i,
    input logic          rd_i,
    input logic [CW-1:0] count_o,
    input logic          wm_o,
    input logic          ovr_o
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_o <= FULL) else $error("count above depth"); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (mode_i && $stable(mode_i) && count_o == FULL && wr_i && !rd_i) |=> (count_o == FULL))
        else $error("full write changed count"); // R3

    AST_POP_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($stable(mode_i) && rd_i && !wr_i && count_o != '0) |=> (count_o == $past(count_o) - CW'(1)))
        else $error("read did not pop"); // R2

    AST_WM_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ($stable(wm_level_i) && $stable(mode_i)) |->
        (wm_o == (mode_i && wm_level_i != '0 && count_o >= CW'(wm_level_i))))
        else $error("watermark mismatch"); // R5

    AST_OVR_FULL: assert property (@(posedge clk) disable iff (rst)
        (mode_i && $stable(mode_i) && count_o == FULL) |-> ovr_o)
        else $error("full without overrun"); // R6

    AST_BYP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !$past(mode_i)) |-> (count_o <= CW'(1)))
        else $error("bypass holds more than one"); // R7

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_i) |=> (count_o == '0 && !wm_o && !ovr_o))
        else $error("mode change did not flush"); // R9

endmodule

bind sample_fifo sample_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .wm_level_i (wm_level_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .count_o    (count_o),
    .wm_o       (wm_o),
    .ovr_o      (ovr_o)
);

// File: tb/sim_sample_fifo.sv
`timescale 1ns/1ps
module sim_sample_fifo;

    localparam int DEPTH = 32;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_i = 1'b0;
    logic [LW-1:0] wm_level_i = '0;
    logic          wr_i = 1'b0;
    logic          rd_i = 1'b0;
    logic [15:0]   x_i = '0, y_i = '0, z_i = '0;
    logic [15:0]   hx, hy, hz;
    logic [CW-1:0] count_o;
    logic          avail_o, wm_o, ovr_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sample_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode_i), .wm_level_i(wm_level_i),
        .wr_i(wr_i), .x_i(x_i), .y_i(y_i), .z_i(z_i), .rd_i(rd_i),
        .head_x_o(hx), .head_y_o(hy), .head_z_o(hz),
        .count_o(count_o), .avail_o(avail_o), .wm_o(wm_o), .ovr_o(ovr_o)
    );

    function automatic logic [47:0] pat(input int k);
        logic [15:0] a, b, c;
        a = 16'(k) + 16'h1000;
        b = 16'(k * 7);
        c = 16'(k) ^ 16'h5A5A;
        return {a, b, c};
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input int key);
        @(negedge clk);
        wr_i = w;
        rd_i = r;
        {x_i, y_i, z_i} = pat(key);
        @(posedge clk);
        #1;
        wr_i = 1'b0;
        rd_i = 1'b0;
    endtask

    task automatic state(input string req, input int cnt, input bit wm, input bit ovr);
        chk({req, " count"}, count_o, cnt);
        chk({req, " avail R10"}, avail_o, cnt != 0);
        chk({req, " wm"}, wm_o, wm);
        chk({req, " ovr"}, ovr_o, ovr);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        state("R1 reset", 0, 0, 0);

        // bypass mode
        step(0, 1, 0);            state("R11 empty read", 0, 0, 0);
        step(1, 0, 1);            state("R7 first write", 1, 0, 0);
        chk("R7 head", {hx, hy, hz}, pat(1));
        step(1, 0, 2);            state("R8 overwrite", 1, 0, 1);
        chk("R7 latest head", {hx, hy, hz}, pat(2));
        step(0, 1, 0);            state("R8 read clears", 0, 0, 0);
        step(1, 0, 3);
        step(1, 1, 4);            state("R8 write with read", 1, 0, 0);
        chk("R7 head after swap", {hx, hy, hz}, pat(4));

        // switch to buffered with a write in the same cycle
        mode_i = 1'b1;
        step(1, 0, 5);            state("R9 flush to fifo", 0, 0, 0);

        wm_level_i = LW'(5);
        for (int i = 0; i < 34; i++) begin
            int e;
            step(1, 0, (i < 32) ? 100 + i : 999);
            e = (i + 1 > 32) ? 32 : i + 1;
            chk("R3 fill count", count_o, e);
            chk("R5 fill wm", wm_o, e >= 5);
            chk("R6 fill ovr", ovr_o, e == 32);
            chk("R2 head oldest", {hx, hy, hz}, pat(100));
        end
        step(1, 1, 132);          state("R4 full rd+wr", 32, 1, 1);
        chk("R4 head advanced", {hx, hy, hz}, pat(101));

        for (int j = 0; j < 32; j++) begin
            chk("R2 order", {hx, hy, hz}, pat(101 + j));
            step(0, 1, 0);
            chk("R2 pop count", count_o, 31 - j);
            chk("R5 drain wm", wm_o, (31 - j) >= 5);
            chk("R6 drain ovr", ovr_o, 0);
        end
        step(0, 1, 0);            state("R11 empty fifo read", 0, 0, 0);

        wm_level_i = '0;
        step(1, 0, 200);
        step(1, 0, 201);          state("R5 level zero", 2, 0, 0);
        chk("R2 head level zero", {hx, hy, hz}, pat(200));
        step(0, 1, 0);
        step(0, 1, 0);

        // watermark sweep over every nonzero level
        for (int lv = 1; lv < DEPTH; lv++) begin
            wm_level_i = LW'(lv);
            for (int n = 1; n <= lv; n++) begin
                step(1, 0, n);
                chk("R5 sweep rise", wm_o, n >= lv);
            end
            step(0, 1, 0);
            chk("R5 sweep fall", wm_o, 0);
            for (int n = 1; n < lv; n++) step(0, 1, 0);
            chk("R2 sweep empty", count_o, 0);
        end

        // back to bypass with content present
        step(1, 0, 300);
        step(1, 0, 301);
        mode_i = 1'b0;
        step(1, 1, 7);            state("R9 flush to bypass", 0, 0, 0);
        step(1, 0, 8);            state("R7 bypass again", 1, 0, 0);
        chk("R7 head after flush", {hx, hy, hz}, pat(8));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule